// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This unit performs the 16-bit arithmetic used on register pairs in an 8-bit processor core: plain addition into the accumulator pair, addition with carry, subtraction with borrow, and increment and decrement by one. Each cycle the core presents an operation code, two 16-bit operands and the current flag byte, and raises a strobe. On the next clock edge the unit presents the 16-bit result, the updated flag byte and an output valid bit.

The operations differ mainly in which flags they touch. Plain addition changes only the half-carry, subtract and carry flags. Addition with carry and subtraction with borrow rewrite every documented flag, including signed overflow. Increment and decrement leave the flag byte alone. The two undocumented flag bits are never computed here and always pass through unchanged.

Top module: `pair_arith16`

## Requirements
- R1: While reset is high, and on the edge where it is sampled high, the result, the flag byte and the output valid bit all go to zero.
- R2: On a rising edge with the strobe high, the result and flag outputs load the values for the presented inputs, and the output valid bit goes high. On an edge with the strobe low, the output valid bit goes low and the result and flags keep their previous values.
- R3: Op code 0 (add) gives a+b modulo 65536. The flag byte has S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. For add, H is the carry from bit 11 into bit 12, C is the carry out of bit 15 and N is 0. S, Z and P/V keep their input values.
- R4: Op code 1 (add with carry) gives a+b+C_in. S is result bit 15, Z is set only for a zero result, H is the carry from bit 11 into bit 12, P/V is signed 16-bit overflow, N is 0, and C is the carry out of bit 15.
- R5: Op code 2 (subtract with borrow) gives a-b-C_in modulo 65536. S and Z follow the rule for op code 1. H is the borrow into bit 12, P/V is signed overflow of the subtraction, N is 1, and C is the borrow out of bit 15.
- R6: Op code 3 gives a+1 and op code 4 gives a-1, both wrapping at 16 bits. Both leave the output flag byte equal to the input flag byte, and operand b has no effect on them.
- R7: For every operation, flag bits 5 and 3 of the output equal the same bits of the input flag byte.
- R8: Op codes 5, 6 and 7 are reserved. They give operand a unchanged as the result and leave the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Strobe: capture a result on this edge |
| op_i | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement) |
| opa_i | input | 16 | First operand (destination pair) |
| opb_i | input | 16 | Second operand (source pair) |
| flags_i | input | 8 | Current flag byte |
| vld_o | output | 1 | Result valid, one cycle after the strobe |
| res_o | output | 16 | Registered 16-bit result |
| flags_o | output | 8 | Registered updated flag byte |

## Verification
A wrong carry-in selection or a wrong operand inversion shows up in res_o one edge after the strobe, usually as an off-by-one or a two's-complement error. A misrouted flag policy appears in flags_o in that same cycle. Examples are an add that disturbs S, Z or P/V, an increment that alters any flag, or a subtraction with N clear. The half-carry and overflow conditions are internal and have no port of their own, so the bench has to drive carries across bit 11 and sign crossings at bit 15 to make a fault in them visible at flags_o. Vectors whose carry or overflow stays clear would hide such a fault.

// File: rtl/pair_arith_pkg.sv
package pair_arith_pkg;
  typedef enum logic [2:0] {
    PA_ADD = 3'd0,
    PA_ADC = 3'd1,
    PA_SBC = 3'd2,
    PA_INC = 3'd3,
    PA_DEC = 3'd4
  } pa_op_e;

  localparam int FLAG_W = 8;
  localparam int FL_C   = 0;
  localparam int FL_N   = 1;
  localparam int FL_PV  = 2;
  localparam int FL_H   = 4;
  localparam int FL_Z   = 6;
  localparam int FL_S   = 7;
endpackage

// File: rtl/pa_operand.sv
module pa_operand
  import pair_arith_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] opb,
  input  logic         cflag,
  output logic [W-1:0] b_eff,
  output logic         cin,
  output logic         sub
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    b_eff = '0;
    cin   = 1'b0;
    sub   = 1'b0;
    case (op)
      PA_ADD: b_eff = opb;
      PA_ADC: begin b_eff = opb; cin = cflag; end
      PA_SBC: begin b_eff = opb; cin = cflag; sub = 1'b1; end
      PA_INC: b_eff = ONE;
      PA_DEC: begin b_eff = ONE; sub = 1'b1; end
      default: b_eff = '0;
    endcase
  end
endmodule

// File: rtl/pa_core.sv
module pa_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy_out,
  output logic         half_cy,
  output logic         ovf,
  output logic         zero
);
  localparam int HB = W - 4;

  function automatic logic [W:0] wide_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [HB:0] low_add(input logic [HB-1:0] x, input logic [HB-1:0] y,
                                          input logic ci);
    return {1'b0, x} + {1'b0, y} + {{HB{1'b0}}, ci};
  endfunction

  logic [W-1:0] bx;
  logic         cx;
  logic [W:0]   full;
  logic [HB:0]  part;

  always_comb begin
    bx   = sub ? ~b : b;
    cx   = sub ? ~cin : cin;
    full = wide_add(a, bx, cx);
    part = low_add(a[HB-1:0], bx[HB-1:0], cx);
  end

  assign sum     = full[W-1:0];
  assign cy_out  = full[W] ^ sub;
  assign half_cy = part[HB] ^ sub;
  assign ovf     = (a[W-1] == bx[W-1]) && (full[W-1] != a[W-1]);
  assign zero    = (full[W-1:0] == '0);
endmodule

// File: rtl/pa_flags.sv
module pa_flags
  import pair_arith_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [FLAG_W-1:0] fin,
  input  logic              sign,
  input  logic              zero,
  input  logic              half_cy,
  input  logic              cy_out,
  input  logic              ovf,
  output logic [FLAG_W-1:0] fout
);
  always_comb begin
    fout = fin;
    case (op)
      PA_ADD: begin
        fout[FL_H] = half_cy;
        fout[FL_N] = 1'b0;
        fout[FL_C] = cy_out;
      end
      PA_ADC, PA_SBC: begin
        fout[FL_S]  = sign;
        fout[FL_Z]  = zero;
        fout[FL_H]  = half_cy;
        fout[FL_PV] = ovf;
        fout[FL_N]  = (op == PA_SBC);
        fout[FL_C]  = cy_out;
      end
      default: fout = fin;
    endcase
  end
endmodule

// File: rtl/pair_arith16.sv
module pair_arith16
  import pair_arith_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [2:0]        op_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              vld_o,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [W-1:0]      b_eff;
  logic              cin_w, sub_w;
  logic [W-1:0]      sum_w;
  logic              cy_w, half_w, ovf_w, zero_w;
  logic [FLAG_W-1:0] fnext_w;

  pa_operand #(.W(W)) u_operand (
    .op(op_i), .opb(opb_i), .cflag(flags_i[FL_C]),
    .b_eff(b_eff), .cin(cin_w), .sub(sub_w)
  );

  pa_core #(.W(W)) u_core (
    .a(opa_i), .b(b_eff), .cin(cin_w), .sub(sub_w),
    .sum(sum_w), .cy_out(cy_w), .half_cy(half_w), .ovf(ovf_w), .zero(zero_w)
  );

  pa_flags u_flags (
    .op(op_i), .fin(flags_i), .sign(sum_w[W-1]), .zero(zero_w),
    .half_cy(half_w), .cy_out(cy_w), .ovf(ovf_w), .fout(fnext_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o   <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        res_o   <= sum_w;
        flags_o <= fnext_w;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!vld_o && res_o == '0 && flags_o == '0));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> (!vld_o && $stable(res_o) && $stable(flags_o)));

  // R3
  add_keeps_szp_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == PA_ADD) |=>
      (flags_o[FL_S] == $past(flags_i[FL_S]) && flags_o[FL_Z] == $past(flags_i[FL_Z]) &&
       flags_o[FL_PV] == $past(flags_i[FL_PV]) && !flags_o[FL_N]));

  // R4
  wide_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && (op_i == PA_ADC || op_i == PA_SBC)) |=>
      (flags_o[FL_Z] == (res_o == '0) && flags_o[FL_S] == res_o[W-1]));

  // R5
  sbc_sets_n_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == PA_SBC) |=> flags_o[FL_N]);

  // R6
  step_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && (op_i == PA_INC || op_i == PA_DEC)) |=> (flags_o == $past(flags_i)));

  // R7
  undoc_pass_chk: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (flags_o[5] == $past(flags_i[5]) && flags_o[3] == $past(flags_i[3])));

  // R8
  reserved_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i > 3'd4) |=> (res_o == $past(opa_i) && flags_o == $past(flags_i)));
endmodule

// File: tb/test_pair_arith16.sv
`timescale 1ns/1ps
module test_pair_arith16;
  logic        clk = 1'b0;
  logic        rst;
  logic        vld_i;
  logic [2:0]  op_i;
  logic [15:0] opa_i, opb_i;
  logic [7:0]  flags_i;
  logic        vld_o;
  logic [15:0] res_o;
  logic [7:0]  flags_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pair_arith16 i_pair_arith16 (
    .clk(clk), .rst(rst), .vld_i(vld_i), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .flags_i(flags_i), .vld_o(vld_o), .res_o(res_o), .flags_o(flags_o)
  );

  // {op, a, b, flags_in, result, flags_out}
  localparam int NV = 17;
  localparam logic [66:0] VEC [NV] = '{
    {3'd1, 16'h8080, 16'h1010, 8'h00, 16'h9090, 8'h80},
    {3'd0, 16'h0080, 16'h1080, 8'hFF, 16'h1100, 8'hEC},
    {3'd2, 16'h9090, 16'h1010, 8'h00, 16'h8080, 8'h82},
    {3'd4, 16'h0000, 16'h1234, 8'h55, 16'hFFFF, 8'h55},
    {3'd3, 16'h0000, 16'hABCD, 8'hA5, 16'h0001, 8'hA5},
    {3'd0, 16'h0FFF, 16'h0001, 8'h00, 16'h1000, 8'h10},
    {3'd0, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h11},
    {3'd1, 16'h7FFF, 16'h0000, 8'h01, 16'h8000, 8'h94},
    {3'd1, 16'hFFFF, 16'h0000, 8'h01, 16'h0000, 8'h51},
    {3'd2, 16'h0000, 16'h0000, 8'h01, 16'hFFFF, 8'h93},
    {3'd2, 16'h8000, 16'h0001, 8'h00, 16'h7FFF, 8'h16},
    {3'd2, 16'h1234, 16'h1234, 8'h28, 16'h0000, 8'h6A},
    {3'd0, 16'h8000, 16'h8000, 8'hE9, 16'h0000, 8'hE9},
    {3'd5, 16'hBEEF, 16'h1111, 8'h3C, 16'hBEEF, 8'h3C},
    {3'd1, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h40},
    {3'd4, 16'h0001, 16'hFFFF, 8'hFF, 16'h0000, 8'hFF},
    {3'd3, 16'hFFFF, 16'h0000, 8'h00, 16'h0000, 8'h00}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 7, 8, 14: return "R4";
      1, 5, 6:     return "R3";
      2, 9, 10:    return "R5";
      11, 12:      return "R7";
      13:          return "R8";
      default:     return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] f);
    @(negedge clk);
    vld_i = 1'b1; op_i = op; opa_i = a; opb_i = b; flags_i = f;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; vld_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {15'd0, vld_o}, 16'd0);
    chk("R1", res_o, 16'h0000);
    chk("R1", {8'd0, flags_o}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][66:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:24]);
      chk(tag_of(i), res_o, VEC[i][23:8]);
      chk(tag_of(i), {8'd0, flags_o}, {8'd0, VEC[i][7:0]});
      chk("R2", {15'd0, vld_o}, 16'd1);
    end

    // R6: operand b has no effect on increment
    apply(3'd3, 16'h4000, 16'h0000, 8'h12);
    chk("R6", res_o, 16'h4001);
    apply(3'd3, 16'h4000, 16'hFFFF, 8'h12);
    chk("R6", res_o, 16'h4001);
    chk("R6", {8'd0, flags_o}, 16'h0012);

    // R2: strobe low holds outputs
    @(negedge clk);
    vld_i = 1'b0; op_i = 3'd0; opa_i = 16'h1111; opb_i = 16'h2222; flags_i = 8'h00;
    @(negedge clk);
    chk("R2", {15'd0, vld_o}, 16'd0);
    chk("R2", res_o, 16'h4001);
    chk("R2", {8'd0, flags_o}, 16'h0012);

    // R1: reset in mid-run clears outputs
    apply(3'd2, 16'h0000, 16'h0001, 8'h00);
    chk("R5", res_o, 16'hFFFF);
    chk("R5", {8'd0, flags_o}, 16'h0093);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", res_o, 16'h0000);
    chk("R1", {8'd0, flags_o}, 16'h0000);
    chk("R1", {15'd0, vld_o}, 16'd0);
    rst = 1'b0; vld_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule